// File: doc/BRIEF.md
# Audio Level Controller with Hang and Two Recovery Rates

This block is an automatic gain control for audio-rate samples. Each accepted sample is multiplied by a gain held in a register. The result appears one clock later as a saturated 16-bit signed value with 15 fractional bits, so that peaks sit just inside full scale. The same block serves two uses. In receive it lifts weak audio. On the microphone side it levels speech.

The block compares the gained magnitude of every sample against the target of +32767. If a sample would exceed the target, the gain is cut in that same sample so that the output does not clip. A per-sample hang counter is then reloaded. The gain stays where it is until that many further samples have passed without a new peak. After that it rises a little each sample. The rise is a fraction of the present gain, and a select input picks the fast fraction or the slow one. The gain is an unsigned value with 8 integer and 8 fractional bits, kept between 1.0 and 255.0.

Top module: `hang_agc`

## Requirements
- R1: After reset `out_valid` is 0, `out_sample` is 0 and `gain` is 256 (1.0 in 8.8 format).
- R2: A sample taken with `in_valid` high produces `out_valid` high on the next clock, with `out_sample` = saturate16((x * g_used) >>> 8). Here g_used is the stored gain, or the cut gain of R3 when that sample is over target.
- R3: A sample is over target when |x| * gain >= 32768 * 256. The gain then becomes floor(8388352 / |x|), clamped to [256, 65280]. That value is used for this same sample and stored.
- R4: An over-target sample loads the hang counter with `hang_len`. Each later accepted sample that is not over target, taken while the counter is non-zero, decrements the counter and leaves the gain unchanged.
- R5: An accepted sample that is not over target, taken with the counter at zero and `fast_sel` = 1, raises the gain by max(gain >> 6, 1), capped at 65280.
- R6: The same case with `fast_sel` = 0 raises the gain by max(gain >> 10, 1), capped at 65280.
- R7: The gain always stays within [256, 65280]. This holds for full-scale negative input and after long recovery.
- R8: While `in_valid` is low, `gain` and `out_sample` keep their values and `out_valid` is 0.
- R9: With `hang_len` = 0, recovery begins on the first sample after an over-target sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: one audio sample this cycle |
| in_sample | input | 16 | Signed sample, 15 fractional bits |
| fast_sel | input | 1 | 1 selects fast recovery, 0 selects slow |
| hang_len | input | 12 | Hang interval in samples, loaded on each peak |
| out_valid | output | 1 | Strobe for the scaled sample |
| out_sample | output | 16 | Scaled, saturated signed sample |
| gain | output | 16 | Present gain, unsigned 8.8 |

## Verification
The assertions assume that `fast_sel` and `hang_len` are steady while a sample is accepted. The recovery bound for a given cycle is tied to that cycle's rate select. They also assume that reset is held for at least one clock before the first strobe. The stimulus changes rate and hang only together with a new sample. It spaces samples one idle clock apart, and it keeps random amplitudes spread from near silence to full scale, so cuts, hangs and both recovery rates all occur.

// File: rtl/hang_agc_pkg.sv
// Package: shared rate select type for the level controller.
// Assumes: nothing beyond the two recovery rates.
package hang_agc_pkg;
    typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;
endpackage

// File: rtl/agc_limit.sv
// Combinational limiter: decides whether a sample would exceed full scale
// at the present gain, finds the largest gain that keeps it inside, and
// forms the saturated output. Assumes gain is within [GMIN, GMAX].
module agc_limit #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int GF   = 8,
    parameter int GMIN = 256,
    parameter int GMAX = 65280
) (
    input  logic [DW-1:0] x,
    input  logic [GW-1:0] gain_q,
    output logic          over,
    output logic [GW-1:0] g_use,
    output logic [DW-1:0] y
);
    localparam int MW  = DW + 1;
    localparam int PW  = MW + GW;
    localparam int TGT = (1 << (DW - 1)) - 1;
    localparam logic [PW-1:0] LIM = PW'(TGT + 1) << GF;
    localparam logic [PW-1:0] NUM = PW'(TGT) << GF;
    localparam logic signed [PW:0] SMAX = (PW + 1)'(TGT);
    localparam logic signed [PW:0] SMIN = -SMAX - 1;

    logic signed [MW-1:0] xs;
    logic [MW-1:0]        mag;
    logic [PW-1:0]        prod;
    logic [PW-1:0]        quo;
    logic [GW-1:0]        g_cut;
    logic signed [PW:0]   sprod;
    logic signed [PW:0]   shd;

    // Magnitude of the sample and its gained size against the limit.
    always_comb begin
        xs   = {x[DW-1], x};
        mag  = xs[MW-1] ? MW'(-xs) : MW'(xs);
        prod = PW'(mag) * PW'(gain_q);
        over = (prod >= LIM);
    end

    // Largest gain that keeps this sample inside the target, clamped.
    always_comb begin
        quo = NUM / ((mag == '0) ? PW'(1) : PW'(mag));
        if (quo < PW'(GMIN))      g_cut = GW'(GMIN);
        else if (quo > PW'(GMAX)) g_cut = GW'(GMAX);
        else                      g_cut = GW'(quo);
        g_use = over ? g_cut : gain_q;
    end

    // Signed product, rescaled and saturated to the sample width.
    always_comb begin
        sprod = xs * $signed({1'b0, g_use});
        shd   = sprod >>> GF;
        if (shd > SMAX)      y = DW'(TGT);
        else if (shd < SMIN) y = {1'b1, {(DW-1){1'b0}}};
        else                 y = shd[DW-1:0];
    end
endmodule

// File: rtl/agc_hang_ctr.sv
// Hang counter: loads the hang length on each peak and counts down one
// per accepted sample otherwise. Assumes len is steady while tick is high.
module agc_hang_ctr #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload,
    input  logic [HW-1:0] len,
    output logic          expired
);
    logic [HW-1:0] cnt;

    // Reload on a peak, otherwise count towards zero per sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (tick && reload)      cnt <= len;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/agc_gain_reg.sv
// Gain register: takes the cut gain on a peak, holds during hang and
// rises by a shifted fraction of itself afterwards. Assumes g_cut is in range.
module agc_gain_reg
    import hang_agc_pkg::*;
#(
    parameter int GW      = 16,
    parameter int FAST_SH = 6,
    parameter int SLOW_SH = 10,
    parameter int GMIN    = 256,
    parameter int GMAX    = 65280
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          over,
    input  logic [GW-1:0] g_cut,
    input  logic          expired,
    input  rate_e         rate,
    output logic [GW-1:0] gain_q
);
    logic [GW-1:0] step;
    logic [GW:0]   sum;
    logic [GW-1:0] rise;

    // Recovery step: fraction of the gain, never less than one LSB.
    always_comb begin
        step = (rate == RATE_FAST) ? (gain_q >> FAST_SH) : (gain_q >> SLOW_SH);
        if (step == '0) step = GW'(1);
        sum  = {1'b0, gain_q} + {1'b0, step};
        rise = (sum > (GW + 1)'(GMAX)) ? GW'(GMAX) : sum[GW-1:0];
    end

    // Gain update per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)               gain_q <= GW'(GMIN);
        else if (tick && over)    gain_q <= g_cut;
        else if (tick && expired) gain_q <= rise;
    end
endmodule

// File: rtl/hang_agc.sv
// Top: audio level controller with peak cut, hang and two recovery rates.
// Output sample is registered one clock after the input strobe.
// Assumes fast_sel and hang_len are steady while in_valid is high.
module hang_agc
    import hang_agc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int GW      = 16,
    parameter int GF      = 8,
    parameter int HW      = 12,
    parameter int FAST_SH = 6,
    parameter int SLOW_SH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic          fast_sel,
    input  logic [HW-1:0] hang_len,
    output logic          out_valid,
    output logic [DW-1:0] out_sample,
    output logic [GW-1:0] gain
);
    localparam int GMIN = 1 << GF;
    localparam int GMAX = ((1 << GW) - 1) & ~((1 << GF) - 1);

    logic          over;
    logic [GW-1:0] g_use;
    logic [DW-1:0] y;
    logic          expired;
    rate_e         rate;

    assign rate = fast_sel ? RATE_FAST : RATE_SLOW;

    agc_limit #(.DW(DW), .GW(GW), .GF(GF), .GMIN(GMIN), .GMAX(GMAX)) u_limit (
        .x(in_sample), .gain_q(gain), .over(over), .g_use(g_use), .y(y)
    );

    agc_hang_ctr #(.HW(HW)) u_hang (
        .clk(clk), .rst_n(rst_n), .tick(in_valid), .reload(over),
        .len(hang_len), .expired(expired)
    );

    agc_gain_reg #(.GW(GW), .FAST_SH(FAST_SH), .SLOW_SH(SLOW_SH),
                   .GMIN(GMIN), .GMAX(GMAX)) u_gain (
        .clk(clk), .rst_n(rst_n), .tick(in_valid), .over(over),
        .g_cut(g_use), .expired(expired), .rate(rate), .gain_q(gain)
    );

    // Output register: strobe follows input, sample captured on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= y;
        end
    end
endmodule

// File: rtl/hang_agc_chk.sv
// Checker: temporal properties of the level controller, bound to the top.
// Assumes inputs are steady within a strobe cycle.
module hang_agc_chk #(
    parameter int DW      = 16,
    parameter int GW      = 16,
    parameter int GF      = 8,
    parameter int HW      = 12,
    parameter int FAST_SH = 6,
    parameter int SLOW_SH = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_sample,
    input logic          fast_sel,
    input logic [HW-1:0] hang_len,
    input logic          out_valid,
    input logic [DW-1:0] out_sample,
    input logic [GW-1:0] gain
);
    localparam int GMIN = 1 << GF;
    localparam int GMAX = ((1 << GW) - 1) & ~((1 << GF) - 1);
    localparam int TGT  = (1 << (DW - 1)) - 1;

    logic [GW+1:0] fast_lim;
    logic [GW+1:0] slow_lim;
    logic [DW:0]   mag;
    logic          fits;

    // Upper bounds on the next gain and a fit test from the ports alone.
    always_comb begin
        fast_lim = (GW + 2)'(gain) + (GW + 2)'(gain >> FAST_SH) + 1;
        slow_lim = (GW + 2)'(gain) + (GW + 2)'(gain >> SLOW_SH) + 1;
        mag      = in_sample[DW-1] ? (DW + 1)'(-$signed({1'b1, in_sample}))
                                   : (DW + 1)'(in_sample);
        fits     = (64'(mag) * 64'(gain)) < (64'(TGT + 1) << GF);
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(gain) && $stable(out_sample));
    a_r7_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
        gain >= GW'(GMIN) && gain <= GW'(GMAX));
    a_r5_fast_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fast_sel |=> (GW + 2)'(gain) <= $past(fast_lim));
    a_r6_slow_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fast_sel |=> (GW + 2)'(gain) <= $past(slow_lim));
    a_r3_no_cut_when_fits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fits |=> gain >= $past(gain));
endmodule

bind hang_agc hang_agc_chk #(.DW(DW), .GW(GW), .GF(GF), .HW(HW),
                             .FAST_SH(FAST_SH), .SLOW_SH(SLOW_SH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .fast_sel(fast_sel), .hang_len(hang_len), .out_valid(out_valid),
    .out_sample(out_sample), .gain(gain)
);

// File: tb/hang_agc_bench.sv
// Bench: directed corners plus seeded random samples against a reference model.
module hang_agc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        fast_sel = 1'b1;
    logic [11:0] hang_len = '0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic [15:0] gain;

    int n_chk = 0;
    int n_bad = 0;
    longint m_gain = 256;
    longint m_hang = 0;
    longint cycles = 0;
    logic [15:0] hold_out;
    logic [15:0] hold_gain;

    always #2.5 clk = ~clk;

    hang_agc u_hang_agc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .fast_sel(fast_sel), .hang_len(hang_len), .out_valid(out_valid),
        .out_sample(out_sample), .gain(gain)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Send one sample, advance the model, check output, strobe and gain.
    task automatic send(input int x, input bit f, input int hl, input string greq);
        longint mag, gu, q, y, step, ng, xi;
        bit over;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(x); fast_sel = f; hang_len = 12'(hl);
        xi = longint'($signed(16'(x)));
        mag = (xi < 0) ? -xi : xi;
        over = (mag * m_gain) >= (64'd32768 * 256);
        if (over) begin
            q = 8388352 / mag;
            gu = (q < 256) ? 256 : ((q > 65280) ? 65280 : q);
        end else gu = m_gain;
        y = sat16((xi * gu) >>> 8);
        if (over) begin
            ng = gu; m_hang = hl;
        end else if (m_hang != 0) begin
            ng = m_gain; m_hang = m_hang - 1;
        end else begin
            step = f ? (m_gain >> 6) : (m_gain >> 10);
            if (step == 0) step = 1;
            ng = (m_gain + step > 65280) ? 65280 : m_gain + step;
        end
        m_gain = ng;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R2 strobe", longint'(out_valid), 1);
        check($signed(out_sample) == y, "R2 sample", longint'($signed(out_sample)), y);
        check(longint'(gain) == m_gain, greq, longint'(gain), m_gain);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20170217));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_valid === 1'b0, "R1 strobe", longint'(out_valid), 0);
        check(out_sample === 16'd0, "R1 sample", longint'(out_sample), 0);
        check(gain === 16'd256, "R1 gain", longint'(gain), 256);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R7: full-scale negative cut clamps gain at 1.0
        send(-32768, 1'b1, 3, "R7 low clamp");
        // R4: hang holds gain for three quiet samples
        for (int i = 0; i < 3; i++) send(100, 1'b1, 3, "R4 hang hold");
        // R5: counter expired, fast rise
        send(100, 1'b1, 3, "R5 fast rise");
        // R9: zero hang recovers on the next sample
        send(-32768, 1'b1, 0, "R3 cut");
        send(0, 1'b1, 0, "R9 zero hang");
        // R5/R7: long fast recovery reaches the upper cap
        for (int i = 0; i < 500; i++) send(0, 1'b1, 0, "R5 ramp");
        check(gain == 16'd65280, "R7 high clamp", longint'(gain), 65280);
        // R3: small sample at maximum gain is cut to fit
        send(200, 1'b1, 2, "R3 cut at max");
        send(-1000, 1'b0, 2, "R3 cut again");
        // R6: slow rise after hang
        for (int i = 0; i < 40; i++) send(5, 1'b0, 2, "R6 slow rise");

        // R8: idle cycles change nothing
        hold_out = out_sample; hold_gain = gain;
        repeat (5) @(negedge clk);
        check(out_valid === 1'b0, "R8 strobe", longint'(out_valid), 0);
        check(out_sample == hold_out, "R8 sample", longint'(out_sample), longint'(hold_out));
        check(gain == hold_gain, "R8 gain", longint'(gain), longint'(hold_gain));

        // Random mix of amplitudes, rates and hang lengths
        for (int i = 0; i < 2000; i++) begin
            int amp, x, sel;
            sel = int'($urandom_range(0, 3));
            case (sel)
                0: amp = int'($urandom_range(0, 64));
                1: amp = int'($urandom_range(0, 1024));
                2: amp = int'($urandom_range(0, 8192));
                default: amp = int'($urandom_range(0, 32767));
            endcase
            x = ($urandom_range(0, 1) == 1) ? -amp : amp;
            if (amp == 32767 && $urandom_range(0, 1) == 1) x = -32768;
            send(x, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R3 R4 R5 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule